// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder with ALU

This block turns the fixed fields of a 32-bit integer instruction into the strobes that steer a single-cycle datapath, and runs the arithmetic stage those strobes select. A first stage looks only at the 7-bit major opcode. From it, it derives the write, memory, branch and jump strobes and a 2-bit operation class. A second stage combines that class with the 3-bit and 7-bit function fields to pick one 4-bit ALU operation code.

The block also holds the ALU. A multiplexer driven by the operand-select strobe feeds the ALU its second operand: either the second register value or the already-extended immediate. The ALU returns a result and a flag that is set when the result is all zeros. The whole block is combinational. A surrounding core supplies the instruction fields and operand values, then reads back the strobes, the operation code and the result in the same cycle.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: Opcode 0110011 (register arithmetic) drives regWrite=1, aluSrc=0, memToReg=0, memRead=0, memWrite=0, branch=0, isJump=0 and aluOp=10.
- R2: Opcode 0010011 (immediate arithmetic) drives regWrite=1, aluSrc=1, aluOp=10 and every other strobe 0.
- R3: Opcode 0000011 (word load) drives regWrite=1, aluSrc=1, memToReg=1, memRead=1, aluOp=00, and memWrite, branch and isJump 0.
- R4: Opcode 0100011 (word store) drives aluSrc=1, memWrite=1 and aluOp=00. The don't-care memToReg is driven 0, as are regWrite, memRead, branch and isJump.
- R5: Opcode 1100011 (branch if equal) drives branch=1, aluOp=01 and every other strobe 0.
- R6: Opcode 1101111 (jump and link) drives only isJump=1, with aluOp=00.
- R7: Any other opcode drives every strobe to 0 and aluOp to 00, so nothing is written and memory is not touched.
- R8: aluOp 00 always yields ALU code 0010 (add), and aluOp 01 always yields 0110 (subtract), whatever the function fields hold.
- R9: With aluOp 10, funct3 picks the operation: 111 gives AND (0000), 110 gives OR (0001), 010 gives SLT (0111), and 000 gives add (0010) or, when funct7 is 0100000 on a register opcode, subtract (0110). Any other funct3 gives add. For the immediate opcode funct7 is ignored, so 000 always gives add.
- R10: The ALU's second operand is the second register value when aluSrc=0 and the immediate when aluSrc=1. The result is a AND b, a OR b, a+b or a−b (modulo 2^32) as coded. SLT gives 1 in bit 0 when a is less than b as signed numbers, and 0 otherwise.
- R11: zeroFlag is 1 exactly when the ALU result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode field of the instruction |
| funct3 | input | 3 | 3-bit function field |
| funct7 | input | 7 | 7-bit function field |
| rs1Data | input | 32 | First operand (register value) |
| rs2Data | input | 32 | Second register value |
| immData | input | 32 | Sign-extended immediate |
| regWrite | output | 1 | Register file write enable |
| aluSrc | output | 1 | 1 selects immediate as second ALU operand |
| memToReg | output | 1 | 1 selects memory data for write-back |
| memRead | output | 1 | Data memory read enable |
| memWrite | output | 1 | Data memory write enable |
| branch | output | 1 | Instruction is a conditional branch |
| isJump | output | 1 | Instruction is a jump and link |
| aluOp | output | 2 | Operation class from the first stage |
| aluCtl | output | 4 | Final ALU operation code |
| aluResult | output | 32 | ALU result |
| zeroFlag | output | 1 | Result is all zeros |

## Verification
The bench targets the places where the two stages could leak into each other. It feeds loads, stores and branches with function fields set to AND or subtract patterns; a decoder that let those fields through on aluOp 00 or 01 would compute a wrong address or miss a branch. Immediate arithmetic is driven with funct7=0100000, which a decoder that failed to mask funct7 would turn into a subtract. SLT is probed with mixed-sign operands, where an unsigned compare gives the opposite answer. Unlisted opcodes and unlisted funct3 values are checked for the silent no-write state and the add default, which a decoder lacking defaults would turn into stray writes or undefined codes.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;
  localparam int OPC_W = 7;

  localparam logic [OPC_W-1:0] OPC_REG_ARITH = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM_ARITH = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD      = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE     = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH    = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JUMP_LINK = 7'b1101111;

  localparam logic [6:0] FN7_ALT = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } aluCode_e;

  typedef enum logic [1:0] {
    CLS_ADDR = 2'b00,
    CLS_CMP  = 2'b01,
    CLS_FUNC = 2'b10
  } aluClass_e;

  typedef struct packed {
    logic      regWrite;
    logic      aluSrc;
    logic      memToReg;
    logic      memRead;
    logic      memWrite;
    logic      branch;
    logic      isJump;
    aluClass_e aluOp;
  } ctrlStrobes_t;
endpackage

// File: rtl/main_decoder.sv
module main_decoder
  import ctrl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobes_t     strobes
);
  always_comb begin
    strobes = '{regWrite: 1'b0, aluSrc: 1'b0, memToReg: 1'b0, memRead: 1'b0,
                memWrite: 1'b0, branch: 1'b0, isJump: 1'b0, aluOp: CLS_ADDR};
    unique case (opcode)
      OPC_REG_ARITH: begin
        strobes.regWrite = 1'b1;
        strobes.aluOp    = CLS_FUNC;
      end
      OPC_IMM_ARITH: begin
        strobes.regWrite = 1'b1;
        strobes.aluSrc   = 1'b1;
        strobes.aluOp    = CLS_FUNC;
      end
      OPC_LOAD: begin
        strobes.regWrite = 1'b1;
        strobes.aluSrc   = 1'b1;
        strobes.memToReg = 1'b1;
        strobes.memRead  = 1'b1;
      end
      OPC_STORE: begin
        strobes.aluSrc   = 1'b1;
        strobes.memWrite = 1'b1;
      end
      OPC_BRANCH: begin
        strobes.branch = 1'b1;
        strobes.aluOp  = CLS_CMP;
      end
      OPC_JUMP_LINK: begin
        strobes.isJump = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_decoder.sv
module alu_decoder
  import ctrl_dec_pkg::*;
(
  input  aluClass_e  aluOp,
  input  logic       immForm,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output aluCode_e   aluCtl
);
  logic altSelect;

  // the immediate form carries immediate bits where funct7 would sit
  assign altSelect = !immForm && (funct7 == FN7_ALT);

  always_comb begin
    aluCtl = ALU_ADD;
    case (aluOp)
      CLS_ADDR: aluCtl = ALU_ADD;
      CLS_CMP:  aluCtl = ALU_SUB;
      CLS_FUNC: begin
        case (funct3)
          3'b000:  aluCtl = altSelect ? ALU_SUB : ALU_ADD;
          3'b111:  aluCtl = ALU_AND;
          3'b110:  aluCtl = ALU_OR;
          3'b010:  aluCtl = ALU_SLT;
          default: aluCtl = ALU_ADD;
        endcase
      end
      default: aluCtl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import ctrl_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] regB,
  input  logic [XLEN-1:0] immB,
  input  logic            useImm,
  input  aluCode_e        aluCtl,
  output logic [XLEN-1:0] result,
  output logic            isZero
);
  logic [XLEN-1:0] opB;
  logic            lessSigned;

  assign opB        = useImm ? immB : regB;
  assign lessSigned = $signed(opA) < $signed(opB);

  always_comb begin
    case (aluCtl)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, lessSigned};
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic [6:0]      funct7,
  input  logic [XLEN-1:0] rs1Data,
  input  logic [XLEN-1:0] rs2Data,
  input  logic [XLEN-1:0] immData,
  output logic            regWrite,
  output logic            aluSrc,
  output logic            memToReg,
  output logic            memRead,
  output logic            memWrite,
  output logic            branch,
  output logic            isJump,
  output logic [1:0]      aluOp,
  output logic [3:0]      aluCtl,
  output logic [XLEN-1:0] aluResult,
  output logic            zeroFlag
);
  ctrlStrobes_t strobes;
  aluCode_e     aluCode;

  main_decoder i_main (
    .opcode (opcode),
    .strobes(strobes)
  );

  alu_decoder i_aluDec (
    .aluOp  (strobes.aluOp),
    .immForm(strobes.aluSrc),
    .funct3 (funct3),
    .funct7 (funct7),
    .aluCtl (aluCode)
  );

  alu_datapath #(.XLEN(XLEN)) i_dp (
    .opA   (rs1Data),
    .regB  (rs2Data),
    .immB  (immData),
    .useImm(strobes.aluSrc),
    .aluCtl(aluCode),
    .result(aluResult),
    .isZero(zeroFlag)
  );

  assign regWrite = strobes.regWrite;
  assign aluSrc   = strobes.aluSrc;
  assign memToReg = strobes.memToReg;
  assign memRead  = strobes.memRead;
  assign memWrite = strobes.memWrite;
  assign branch   = strobes.branch;
  assign isJump   = strobes.isJump;
  assign aluOp    = strobes.aluOp;
  assign aluCtl   = aluCode;
endmodule

// File: rtl/instr_ctrl_decoder_chk.sv
module instr_ctrl_decoder_chk (
  input logic       regWrite,
  input logic       aluSrc,
  input logic       memToReg,
  input logic       memRead,
  input logic       memWrite,
  input logic       branch,
  input logic       isJump,
  input logic [1:0] aluOp,
  input logic [3:0] aluCtl
);
  always_comb begin
    // R3: a load always writes back memory data through the operand-B immediate
    assert_load_path_R3: assert (!memRead || (memToReg && regWrite && aluSrc))
      else $error("load strobes inconsistent");
    // R7: at most one kind of memory, branch or jump action per instruction
    assert_single_action_R7: assert ($onehot0({memRead, memWrite, branch, isJump}))
      else $error("more than one action strobe");
    // R4: a store never writes the register file
    assert_store_no_write_R4: assert (!(memWrite && regWrite))
      else $error("store with register write");
    // R8: address class always maps to add, compare class to subtract
    assert_class_fixed_R8: assert ((aluOp != 2'b00 || aluCtl == 4'b0010) &&
                                   (aluOp != 2'b01 || aluCtl == 4'b0110))
      else $error("fixed class gave wrong code");
    // R5: a branch compares by subtraction
    assert_branch_sub_R5: assert (!branch || aluCtl == 4'b0110)
      else $error("branch without subtract");
    // R9: the operation code stays inside the legal set
    assert_legal_code_R9: assert (aluCtl inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111})
      else $error("illegal ALU code");
  end
endmodule

bind instr_ctrl_decoder instr_ctrl_decoder_chk i_chk (
  .regWrite(regWrite),
  .aluSrc  (aluSrc),
  .memToReg(memToReg),
  .memRead (memRead),
  .memWrite(memWrite),
  .branch  (branch),
  .isJump  (isJump),
  .aluOp   (aluOp),
  .aluCtl  (aluCtl)
);

// File: tb/test_instr_ctrl_decoder.sv
module test_instr_ctrl_decoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 16;

  typedef struct packed {
    logic [3:0]  req;
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] imm;
    logic [8:0]  ctl;   // regWrite,aluSrc,memToReg,memRead,memWrite,branch,isJump,aluOp[1:0]
    logic [3:0]  code;
    logic [31:0] res;
    logic        zf;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{4'd1,  7'b0110011, 3'b000, 7'b0000000, 32'd5,        32'd7,          32'd0,          9'b100000010, 4'b0010, 32'd12,         1'b0},
    '{4'd1,  7'b0110011, 3'b000, 7'b0100000, 32'd9,        32'd9,          32'd0,          9'b100000010, 4'b0110, 32'd0,          1'b1},
    '{4'd9,  7'b0110011, 3'b111, 7'b0000000, 32'h0000F0F0, 32'h00000FF0,   32'd0,          9'b100000010, 4'b0000, 32'h000000F0,   1'b0},
    '{4'd9,  7'b0110011, 3'b110, 7'b0000000, 32'h0000F000, 32'h0000000F,   32'd0,          9'b100000010, 4'b0001, 32'h0000F00F,   1'b0},
    '{4'd10, 7'b0110011, 3'b010, 7'b0000000, 32'hFFFFFFFF, 32'd1,          32'd0,          9'b100000010, 4'b0111, 32'd1,          1'b0},
    '{4'd10, 7'b0110011, 3'b010, 7'b0000000, 32'd5,        32'hFFFFFFFD,   32'd0,          9'b100000010, 4'b0111, 32'd0,          1'b1},
    '{4'd2,  7'b0010011, 3'b000, 7'b0100000, 32'd10,       32'd99,         32'hFFFFFFFE,   9'b110000010, 4'b0010, 32'd8,          1'b0},
    '{4'd3,  7'b0000011, 3'b010, 7'b0100000, 32'h00000100, 32'd77,         32'd40,         9'b111100000, 4'b0010, 32'h00000128,   1'b0},
    '{4'd4,  7'b0100011, 3'b111, 7'b0000000, 32'h00000200, 32'd5,          32'd8,          9'b010010000, 4'b0010, 32'h00000208,   1'b0},
    '{4'd5,  7'b1100011, 3'b111, 7'b0100000, 32'd3,        32'd3,          32'd50,         9'b000001001, 4'b0110, 32'd0,          1'b1},
    '{4'd5,  7'b1100011, 3'b000, 7'b0000000, 32'd3,        32'd4,          32'd50,         9'b000001001, 4'b0110, 32'hFFFFFFFF,   1'b0},
    '{4'd7,  7'b0110111, 3'b111, 7'b0100000, 32'd1,        32'd2,          32'd100,        9'b000000000, 4'b0010, 32'd3,          1'b0},
    '{4'd9,  7'b0110011, 3'b001, 7'b0100000, 32'd2,        32'd3,          32'd0,          9'b100000010, 4'b0010, 32'd5,          1'b0},
    '{4'd9,  7'b0110011, 3'b000, 7'b0000001, 32'd4,        32'd4,          32'd0,          9'b100000010, 4'b0010, 32'd8,          1'b0},
    '{4'd6,  7'b1101111, 3'b000, 7'b0000000, 32'd0,        32'd0,          32'd64,         9'b000000100, 4'b0010, 32'd0,          1'b1},
    '{4'd2,  7'b0010011, 3'b111, 7'b0000000, 32'h000000FF, 32'h00000F00,   32'h0000000F,   9'b110000010, 4'b0000, 32'h0000000F,   1'b0}
  };

  logic        clk = 1'b0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [31:0] rs1Data = '0, rs2Data = '0, immData = '0;
  logic        regWrite, aluSrc, memToReg, memRead, memWrite, branch, isJump, zeroFlag;
  logic [1:0]  aluOp;
  logic [3:0]  aluCtl;
  logic [31:0] aluResult;
  int          nChecks = 0;
  int          nFails  = 0;
  int          cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_ctrl_decoder i_instr_ctrl_decoder (
    .opcode(opcode), .funct3(funct3), .funct7(funct7),
    .rs1Data(rs1Data), .rs2Data(rs2Data), .immData(immData),
    .regWrite(regWrite), .aluSrc(aluSrc), .memToReg(memToReg),
    .memRead(memRead), .memWrite(memWrite), .branch(branch),
    .isJump(isJump), .aluOp(aluOp), .aluCtl(aluCtl),
    .aluResult(aluResult), .zeroFlag(zeroFlag)
  );

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    opcode = v.opc; funct3 = v.f3; funct7 = v.f7;
    rs1Data = v.a; rs2Data = v.b; immData = v.imm;
    #1;
  endtask

  function automatic logic [8:0] ctlNow();
    return {regWrite, aluSrc, memToReg, memRead, memWrite, branch, isJump, aluOp};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        nFails++; nChecks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
        $finish;
      end
    end
  end

  initial begin
    // R7: all-zero inputs out of reset give the quiet state
    @(negedge clk); #1;
    check("R7", "idle strobes", {23'd0, ctlNow()}, 32'd0);
    check("R8", "idle code", {28'd0, aluCtl}, 32'h2);
    check("R11", "idle zero", {31'd0, zeroFlag}, 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      apply(TBL[i]);
      check(reqName(TBL[i].req), "strobes", {23'd0, ctlNow()}, {23'd0, TBL[i].ctl});
      check("R9", "alu code", {28'd0, aluCtl}, {28'd0, TBL[i].code});
      check("R10", "result", aluResult, TBL[i].res);
      check("R11", "zero flag", {31'd0, zeroFlag}, {31'd0, TBL[i].zf});
    end

    // R8: store with every funct pattern still adds
    for (int f = 0; f < 8; f++) begin
      apply('{4'd8, 7'b0100011, f[2:0], 7'b0100000, 32'd20, 32'd0, 32'd4,
              9'b010010000, 4'b0010, 32'd24, 1'b0});
      check("R8", "store code", {28'd0, aluCtl}, 32'h2);
    end

    // R11: AND producing zero sets the flag
    apply('{4'd11, 7'b0110011, 3'b111, 7'b0000000, 32'hAAAA0000, 32'h5555FFFF, 32'd0,
            9'b100000010, 4'b0000, 32'd0, 1'b1});
    check("R11", "and zero", {31'd0, zeroFlag}, 32'd1);

    // R10: SLT on most-negative versus most-positive
    apply('{4'd10, 7'b0110011, 3'b010, 7'b0000000, 32'h80000000, 32'h7FFFFFFF, 32'd0,
            9'b100000010, 4'b0111, 32'd1, 1'b0});
    check("R10", "slt extremes", aluResult, 32'd1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule